// File: doc/BRIEF.md
# Multi-Mode Waveform Timer

This block is a 16-bit timer/counter with four compare channels. A 3-bit mode selects the counting pattern, where the counter turns around (its TOP), the moment at which the buffered period and compare values move into the active copies, when the overflow pulse fires, and how each channel builds its waveform. The available patterns are a free-running up-counter, frequency generation with channel A as TOP, single-slope PWM, and three dual-slope PWM variants that differ only in overflow timing.

Software programs the block through a plain single-cycle write port: `wr_en` with `wr_addr` and `wr_data`, and no handshake. Every write lands on the clock edge where `wr_en` is high. The register addresses are:
- 0: control, with `wr_data[2:0]` as the mode and `wr_data[3]` as run.
- 1: period.
- 2 to 5: compare values for channels A to D.
- 6: output enables in `wr_data[3:0]`, bit i for channel i.
- 7: direct output bits in `wr_data[3:0]`.

The block drives four waveform pins, a one-cycle overflow pulse, and one compare-match pulse per channel. Every output except the pins comes from a register and lags the counter state that caused it by one clock.

Top module: `pwm_timer`

## Requirements
- R1: Mode encodings are 000 normal, 001 frequency, 011 single-slope, 101/110/111 dual-slope. Encodings 010 and 100 are reserved. In a reserved mode the counter holds its value, and no overflow, compare pulse or waveform change occurs.
- R2: TOP is the period register in every mode except frequency mode, where TOP is the active channel A compare value.
- R3: While the timer runs, period and compare writes go only to buffers. The buffers are copied into the active registers at TOP in normal and frequency modes, and at BOTTOM (count 0) in single-slope and dual-slope modes. While the timer is off, these writes take effect at once.
- R4: The overflow pulse fires:
  - at TOP in normal and frequency modes;
  - at BOTTOM in single-slope mode;
  - at TOP for 101;
  - at TOP and at BOTTOM for 110;
  - at BOTTOM for 111.
- R5: In single-slope mode the counter runs 0..TOP and wraps to 0. A channel is set when the count is 0 and cleared when the count equals its compare value. The clear wins if both happen together.
- R6: In dual-slope mode the counter runs up to TOP and back down to 0. A channel is cleared on a compare match while counting up and set on a match while counting down.
- R7: In frequency mode the counter clears after reaching channel A's value, and channel A's waveform toggles at each clear.
- R8: In normal mode the waveforms keep their present values.
- R9: A pin carries its channel's waveform only when that channel's enable bit is set. Otherwise the pin is low.
- R10: A write to the direct output bits sets each channel's waveform to the written bit while run is 0. The same write has no effect while run is 1.
- R11: Each channel's compare-match flag pulses for one clock after the counter equals that channel's active compare value, in any non-reserved mode while running.
- R12: After reset the counter, waveforms, pins, overflow and flags are zero, the mode is normal and the timer is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| wave_o | output | 4 | Gated waveform pins, bit i is channel i |
| ovf_o | output | 1 | Overflow pulse |
| cmp_flag_o | output | 4 | Compare-match pulses, bit i is channel i |

## Verification
The hardest case to reach is a period write that lands mid-cycle while the counter is already above the new period. A design without buffering would let the counter run past the new TOP all the way to 65535, whereas a buffered one finishes the current cycle first. The bench reaches this case by aligning to an observed overflow pulse in single-slope mode. It then counts a known number of clocks so that the counter is at 7 with a period of 9, writes a period of 3, and checks that the spacing between overflow pulses settles to 4. A table of mode vectors covers every encoding, including both reserved ones, by measuring overflow spacing, high time on channel A and flag count over a 100-cycle window.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [2:0] {
    M_NORMAL  = 3'd0,
    M_FREQ    = 3'd1,
    M_RSV2    = 3'd2,
    M_SINGLE  = 3'd3,
    M_RSV4    = 3'd4,
    M_DUAL_T  = 3'd5,
    M_DUAL_TB = 3'd6,
    M_DUAL_B  = 3'd7
  } mode_e;

  function automatic logic is_reserved(input mode_e m);
    return (m == M_RSV2) || (m == M_RSV4);
  endfunction

  function automatic logic is_dual(input mode_e m);
    return (m == M_DUAL_T) || (m == M_DUAL_TB) || (m == M_DUAL_B);
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    upd,
  output mode_e                   mode,
  output logic                    run,
  output logic [CW-1:0]           per_act,
  output logic [NCH-1:0][CW-1:0]  cmp_act,
  output logic [NCH-1:0]          oe,
  output logic                    force_we,
  output logic [NCH-1:0]          force_val
);
  localparam int A_CTRL = 0;
  localparam int A_PER  = 1;
  localparam int A_CMP0 = 2;
  localparam int A_OE   = A_CMP0 + NCH;
  localparam int A_DIR  = A_OE + 1;

  logic [CW-1:0] per_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_NORMAL;
      run  <= 1'b0;
      oe   <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTRL)) begin
        mode <= mode_e'(wr_data[2:0]);
        run  <= wr_data[3];
      end
      if (wr_addr == AW'(A_OE)) oe <= wr_data[NCH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf <= '0;
      per_act <= '0;
    end else begin
      if (wr_en && wr_addr == AW'(A_PER)) begin
        per_buf <= wr_data;
        if (!run) per_act <= wr_data;
      end else if (upd) begin
        per_act <= per_buf;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    logic [CW-1:0] cmp_buf;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_buf    <= '0;
        cmp_act[i] <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(A_CMP0 + i)) begin
          cmp_buf <= wr_data;
          if (!run) cmp_act[i] <= wr_data;
        end else if (upd) begin
          cmp_act[i] <= cmp_buf;
        end
      end
    end
  end

  assign force_we  = wr_en && (wr_addr == AW'(A_DIR)) && !run;
  assign force_val = wr_data[NCH-1:0];
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  mode_e         mode,
  input  logic [CW-1:0] per_act,
  input  logic [CW-1:0] cmpa_act,
  output logic [CW-1:0] cnt,
  output logic          dir_down,
  output logic          active,
  output logic          at_top,
  output logic          at_bot,
  output logic          upd,
  output logic          ovf
);
  logic [CW-1:0] top;
  logic          ovf_d;

  assign top    = (mode == M_FREQ) ? cmpa_act : per_act;
  assign active = run && !is_reserved(mode);
  assign at_top = active && (cnt == top);
  assign at_bot = active && (cnt == '0);

  always_comb begin
    case (mode)
      M_NORMAL, M_FREQ: upd = at_top;
      default:          upd = at_bot;
    endcase
    case (mode)
      M_NORMAL, M_FREQ, M_DUAL_T: ovf_d = at_top;
      M_SINGLE, M_DUAL_B:         ovf_d = at_bot;
      M_DUAL_TB:                  ovf_d = at_top || at_bot;
      default:                    ovf_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      ovf <= ovf_d;
      if (active) begin
        if (is_dual(mode)) begin
          if (!dir_down) begin
            if (cnt >= top) begin
              dir_down <= 1'b1;
              cnt      <= (cnt == '0) ? '0 : cnt - 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt == '0) begin
            dir_down <= 1'b0;
            cnt      <= (top == '0) ? '0 : CW'(1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          dir_down <= 1'b0;
          cnt      <= at_top ? '0 : cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  mode_e                  mode,
  input  logic                   active,
  input  logic [CW-1:0]          cnt,
  input  logic                   dir_down,
  input  logic                   at_top,
  input  logic                   at_bot,
  input  logic [NCH-1:0][CW-1:0] cmp_act,
  input  logic                   force_we,
  input  logic [NCH-1:0]         force_val,
  output logic [NCH-1:0]         wg,
  output logic [NCH-1:0]         cmpf
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic match;
    assign match = active && (cnt == cmp_act[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wg[i]   <= 1'b0;
        cmpf[i] <= 1'b0;
      end else begin
        cmpf[i] <= match;
        if (force_we) begin
          wg[i] <= force_val[i];
        end else if (active) begin
          case (mode)
            M_FREQ: if (i == 0 && at_top) wg[i] <= ~wg[i];
            M_SINGLE: begin
              if (match)       wg[i] <= 1'b0;
              else if (at_bot) wg[i] <= 1'b1;
            end
            M_DUAL_T, M_DUAL_TB, M_DUAL_B: if (match) wg[i] <= dir_down;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  localparam int AW = $clog2(NCH + 4)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] wave_o,
  output logic           ovf_o,
  output logic [NCH-1:0] cmp_flag_o
);
  mode_e                  mode_q;
  logic                   run_q;
  logic [CW-1:0]          per_act;
  logic [NCH-1:0][CW-1:0] cmp_act;
  logic [NCH-1:0]         oe_q;
  logic                   force_we;
  logic [NCH-1:0]         force_val;
  logic [CW-1:0]          cnt;
  logic                   dir_down, active, at_top, at_bot, upd;
  logic [NCH-1:0]         wg;

  pwm_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .upd,
    .mode(mode_q), .run(run_q), .per_act, .cmp_act, .oe(oe_q),
    .force_we, .force_val
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk, .rst_n, .run(run_q), .mode(mode_q), .per_act,
    .cmpa_act(cmp_act[0]), .cnt, .dir_down, .active, .at_top, .at_bot,
    .upd, .ovf(ovf_o)
  );

  pwm_wavegen #(.NCH(NCH), .CW(CW)) u_wave (
    .clk, .rst_n, .mode(mode_q), .active, .cnt, .dir_down, .at_top,
    .at_bot, .cmp_act, .force_we, .force_val, .wg, .cmpf(cmp_flag_o)
  );

  assign wave_o = wg & oe_q;
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           run,
  input mode_e          mode,
  input logic [CW-1:0]  cnt,
  input logic [NCH-1:0] wave,
  input logic [NCH-1:0] cmpf,
  input logic           ovf
);
  a_r1_reserved_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run && is_reserved(mode) && !wr_en) |=> $stable(cnt));

  a_r1_reserved_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    is_reserved(mode) |=> !ovf);

  a_r4_off_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ovf);

  a_r8_normal_holds_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == M_NORMAL && !wr_en) |=> $stable(wave));

  a_r11_flag_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpf != '0) |-> $past(run));
endmodule

bind pwm_timer pwm_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .run(run_q), .mode(mode_q),
  .cnt(cnt), .wave(wave_o), .cmpf(cmp_flag_o), .ovf(ovf_o)
);

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  // mode, period, compare A, overflow spacing, A high cycles, A flag count
  localparam int V_MODE [NV] = '{0, 1, 3, 5, 6, 7, 2, 4};
  localparam int V_PER  [NV] = '{9, 9, 9, 5, 5, 5, 9, 9};
  localparam int V_CMPA [NV] = '{3, 4, 3, 2, 2, 2, 3, 3};
  localparam int V_IVL  [NV] = '{10, 5, 10, 10, 5, 10, 0, 0};
  localparam int V_HIGH [NV] = '{0, 50, 30, 40, 40, 40, 0, 0};
  localparam int V_FLAG [NV] = '{10, 20, 10, 20, 20, 20, 0, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  wave_o;
  logic        ovf_o;
  logic [3:0]  cmp_flag_o;
  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_timer u_dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data,
                   .wave_o, .ovf_o, .cmp_flag_o);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic measure(input int n, output int ivl, output int high, output int flags);
    int t1 = -1, t2 = -1;
    high = 0; flags = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      high  += int'(wave_o[0]);
      flags += int'(cmp_flag_o[0]);
      if (ovf_o) begin
        if (t1 < 0) t1 = c;
        else if (t2 < 0) t2 = c;
      end
    end
    ivl = (t2 >= 0) ? t2 - t1 : 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ivl, high, flags;
    // R12: reset state
    do_reset();
    @(negedge clk);
    chk("R12 pins", int'(wave_o), 0);
    chk("R12 overflow", int'(ovf_o), 0);
    chk("R12 flags", int'(cmp_flag_o), 0);

    // Mode table: R1 reserved, R2 TOP source, R4 overflow, R5..R8 waves, R11 flags
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr(6, 1);
      wr(1, V_PER[v]);
      wr(2, V_CMPA[v]);
      wr(0, 8 | V_MODE[v]);
      repeat (40) @(negedge clk);
      measure(100, ivl, high, flags);
      chk($sformatf("R4/R2/R1 overflow spacing mode %0d", V_MODE[v]), ivl, V_IVL[v]);
      chk($sformatf("R5/R6/R7/R8/R1 high time mode %0d", V_MODE[v]), high, V_HIGH[v]);
      chk($sformatf("R11/R1 flag count mode %0d", V_MODE[v]), flags, V_FLAG[v]);
    end

    // R10: direct bits while off; R8: normal holds; R9: enable gating
    do_reset();
    wr(6, 15);
    wr(7, 4'b1010);
    @(negedge clk);
    chk("R10 direct write while off", int'(wave_o), 4'b1010);
    wr(1, 9);
    wr(0, 8);
    repeat (25) @(negedge clk);
    chk("R8 normal mode keeps outputs", int'(wave_o), 4'b1010);
    wr(7, 4'b0101);
    @(negedge clk);
    chk("R10 direct write ignored while running", int'(wave_o), 4'b1010);
    wr(6, 0);
    repeat (5) @(negedge clk);
    chk("R9 disabled pins low", int'(wave_o), 0);
    wr(6, 4'b0011);
    @(negedge clk);
    chk("R9 partial enable", int'(wave_o), 4'b0010);

    // R9: single-slope running with channel A disabled never reaches pin
    do_reset();
    wr(1, 9); wr(2, 3); wr(0, 8 | 3);
    high = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      high += int'(wave_o[0]);
    end
    chk("R9 running channel gated", high, 0);

    // R3: shorter period written mid-cycle waits for BOTTOM
    do_reset();
    wr(6, 1); wr(1, 9); wr(2, 3); wr(0, 8 | 3);
    do @(negedge clk); while (!ovf_o);
    // count is now 1; the write lands after 6 more clocks at count 7
    repeat (5) @(negedge clk);
    wr(1, 3);
    repeat (20) @(negedge clk);
    measure(30, ivl, high, flags);
    chk("R3 buffered period update", ivl, 4);

    // R3: while off a period write is immediate
    do_reset();
    wr(1, 4); wr(0, 8 | 3);
    repeat (12) @(negedge clk);
    measure(30, ivl, high, flags);
    chk("R3 off-state period write direct", ivl, 5);

    // R12: reset mid-run clears outputs
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset during run", int'(wave_o) + int'(ovf_o) + int'(cmp_flag_o), 0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule